// File: doc/BRIEF.md
# Phase Accumulator Waveform Synthesizer

This block is a direct digital synthesis core. A wide phase register advances by a programmable frequency word on every clock. The register's most significant bits, shifted by a coarse phase offset, index a table of signed sine amplitudes. The output frequency is fclk × word / 2^ACC_W, so the frequency step is fclk / 2^ACC_W. The low bits of the phase are dropped before the table lookup. A comparator-style square wave is taken from the sign of the selected sample.

Control values are applied as a set when a load strobe is high. These values are the frequency word, a 5-bit phase offset and a power-down flag. Input changes made without the strobe have no effect. In power-down the phase register returns to zero and both outputs read zero. When power-down is released, the waveform starts again from phase zero.

The sample stream is meant for an external converter and reconstruction filter. Each table address is registered, and each looked-up sample is registered, so the amplitude trails the phase register by two cycles.

Top module: `phase_synth_core`

## Requirements
- R1: While reset is asserted and after it is released, with no load applied, amp_out reads 0 and sq_out reads 0. The phase register and the latched controls are zero.
- R2: On each clock edge without power-down, the phase register takes its previous value plus the latched frequency word, modulo 2^32. Words of 2^31 and above wrap around correctly.
- R3: Only phase bits [31:22] form the table address. A frequency word below 2^22 applied from phase zero leaves the address at 0 until the accumulated phase reaches 2^22.
- R4: Table entry k (0..1023) holds round(2047 × sin(2πk/1024)) as a signed 12-bit value.
- R5: The latched 5-bit phase offset p is added, modulo 1024, to the top five address bits. The address is therefore phase[31:22] + 32·p, which gives steps of 11.25 degrees.
- R6: freq_word, phase_word and power_down are captured only on a clock edge where load is 1. At any other edge they are ignored.
- R7: While the latched power-down flag is 1, the phase register is forced to zero. From the second edge after the flag is latched, amp_out is 0 and sq_out is 0. After release, the phase restarts from zero.
- R8: sq_out is 1 exactly when amp_out is strictly greater than zero.
- R9: A sample reaches amp_out two clock edges after the phase value that addresses it is present in the phase register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture strobe for the control inputs |
| freq_word | input | 32 | Phase increment per clock |
| phase_word | input | 5 | Coarse phase offset, 11.25 degrees per step |
| power_down | input | 1 | 1 stops the synthesizer and zeroes the outputs |
| amp_out | output | 12 | Signed sine sample |
| sq_out | output | 1 | Square wave, 1 while the sample is positive |

## Verification
The frequency word 2^22 steps the address by exactly one per clock, so 1100 consecutive samples cover every table entry. This pass also exposes any error in table content, address slicing or pipeline latency. A word of 1 must leave the output at the zero entry, which separates truncation from full-phase addressing. A word above 2^31 separates correct modular wrap from saturation or sign errors. A sweep of all 32 offsets with a zero word, plus changes to the control inputs made without the strobe, isolates the offset adder and the load gating. A power-down cycle followed by release checks both the zeroed outputs and the restart from phase zero.

// File: rtl/psc_pkg.sv
package psc_pkg;

   // Rounded sine sample for table index idx, full scale 2^(ampw-1)-1.
   function automatic int sine_sample(input int idx, input int aw, input int ampw);
      real ang;
      real v;
      real full;
      full = real'((1 << (ampw - 1)) - 1);
      ang  = 2.0 * 3.14159265358979 * real'(idx) / (2.0 ** aw);
      v    = $sin(ang) * full;
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(-v + 0.5);
   endfunction

endpackage

// File: rtl/psc_ctrl_latch.sv
module psc_ctrl_latch #(
   parameter int ACC_W = 32,
   parameter int PHW   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ACC_W-1:0] freq_in,
   input  logic [PHW-1:0]   phase_in,
   input  logic             pd_in,
   output logic [ACC_W-1:0] freq_q,
   output logic [PHW-1:0]   phase_q,
   output logic             pd_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_q  <= '0;
         phase_q <= '0;
         pd_q    <= 1'b0;
      end else if (load) begin
         freq_q  <= freq_in;
         phase_q <= phase_in;
         pd_q    <= pd_in;
      end
   end

endmodule

// File: rtl/psc_accum.sv
module psc_accum #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] step,
   input  logic             hold_zero,
   output logic [ACC_W-1:0] phase
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         phase <= '0;
      else if (hold_zero) phase <= '0;
      else                phase <= phase + step;
   end

endmodule

// File: rtl/psc_sine_rom.sv
module psc_sine_rom #(
   parameter int ADDR_W = 10,
   parameter int AMP_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    blank,
   output logic signed [AMP_W-1:0] amp,
   output logic                    sq
);

   localparam int DEPTH = 1 << ADDR_W;

   logic signed [AMP_W-1:0] rom [DEPTH];
   logic signed [AMP_W-1:0] sel;

   for (genvar i = 0; i < DEPTH; i++) begin : g_tab
      localparam int VAL = psc_pkg::sine_sample(i, ADDR_W, AMP_W);
      assign rom[i] = VAL[AMP_W-1:0];
   end

   assign sel = rom[addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         amp <= '0;
         sq  <= 1'b0;
      end else if (blank) begin
         amp <= '0;
         sq  <= 1'b0;
      end else begin
         amp <= sel;
         sq  <= (sel > 0);
      end
   end

endmodule

// File: rtl/phase_synth_core.sv
module phase_synth_core #(
   parameter int ACC_W  = 32,
   parameter int ADDR_W = 10,
   parameter int AMP_W  = 12,
   parameter int PHW    = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [ACC_W-1:0]        freq_word,
   input  logic [PHW-1:0]          phase_word,
   input  logic                    power_down,
   output logic signed [AMP_W-1:0] amp_out,
   output logic                    sq_out
);

   localparam int PAD_W = ADDR_W - PHW;

   if (ADDR_W > ACC_W) begin : g_bad_addr
      $error("ADDR_W must not exceed ACC_W");
   end
   if (PHW > ADDR_W) begin : g_bad_phw
      $error("PHW must not exceed ADDR_W");
   end
   if (AMP_W < 2) begin : g_bad_amp
      $error("AMP_W must be at least 2");
   end

   logic [ACC_W-1:0]  freq_q;
   logic [PHW-1:0]    phase_q;
   logic              pd_q;
   logic [ACC_W-1:0]  acc;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] addr_q;
   logic              pd_d1;

   psc_ctrl_latch #(.ACC_W(ACC_W), .PHW(PHW)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .freq_in (freq_word),
      .phase_in(phase_word),
      .pd_in   (power_down),
      .freq_q  (freq_q),
      .phase_q (phase_q),
      .pd_q    (pd_q)
   );

   psc_accum #(.ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (freq_q),
      .hold_zero(pd_q),
      .phase    (acc)
   );

   if (PAD_W > 0) begin : g_off_pad
      assign offset = {phase_q, {PAD_W{1'b0}}};
   end else begin : g_off_full
      assign offset = phase_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         pd_d1  <= 1'b0;
      end else begin
         addr_q <= acc[ACC_W-1 -: ADDR_W] + offset;
         pd_d1  <= pd_q;
      end
   end

   psc_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
      .clk  (clk),
      .rst_n(rst_n),
      .addr (addr_q),
      .blank(pd_d1),
      .amp  (amp_out),
      .sq   (sq_out)
   );

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
   parameter int ACC_W = 32,
   parameter int PHW   = 5,
   parameter int AMP_W = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    load,
   input logic [ACC_W-1:0]        freq_q,
   input logic [PHW-1:0]          phase_q,
   input logic                    pd_q,
   input logic [ACC_W-1:0]        acc,
   input logic signed [AMP_W-1:0] amp_out,
   input logic                    sq_out
);

   AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pd_q) |-> acc == $past(acc) + $past(freq_q)) else $error("acc step"); // R2

   AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pd_q |=> acc == '0) else $error("pd hold"); // R7

   AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pd_q |=> ##1 (amp_out == '0 && !sq_out)) else $error("pd quiet"); // R7

   AST_LOAD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(freq_q) && $stable(phase_q) && $stable(pd_q))) else $error("load gate"); // R6

   AST_SQ_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      sq_out == (amp_out > 0)) else $error("square sign"); // R8

endmodule

bind phase_synth_core psc_checker #(.ACC_W(ACC_W), .PHW(PHW), .AMP_W(AMP_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .load   (load),
   .freq_q (freq_q),
   .phase_q(phase_q),
   .pd_q   (pd_q),
   .acc    (acc),
   .amp_out(amp_out),
   .sq_out (sq_out)
);

// File: tb/sim_phase_synth_core.sv
module sim_phase_synth_core;

   localparam int CLK_PERIOD = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               load_i = 1'b0;
   logic [31:0]        freq_i = '0;
   logic [4:0]         ph_i = '0;
   logic               pd_i = 1'b0;
   logic signed [11:0] amp;
   logic               sq;

   int checks = 0;
   int errors = 0;
   int ref_tab [1024];

   // reference model state
   logic [31:0] m_acc, m_fq;
   logic [4:0]  m_ph;
   logic        m_pd, m_pd1;
   logic [9:0]  m_addr1;
   int          m_amp;
   logic        m_sq;

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_synth_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_i),
      .freq_word (freq_i),
      .phase_word(ph_i),
      .power_down(pd_i),
      .amp_out   (amp),
      .sq_out    (sq)
   );

   function automatic int ref_sine(input int k);
      real v;
      v = $sin(2.0 * 3.14159265358979 * real'(k) / 1024.0) * 2047.0;
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(-v + 0.5);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_acc = '0; m_fq = '0; m_ph = '0; m_pd = 1'b0; m_pd1 = 1'b0;
      m_addr1 = '0; m_amp = 0; m_sq = 1'b0;
   endtask

   // one clock: update model at the edge, compare at the falling edge
   task automatic tick(input string tag);
      @(posedge clk);
      m_amp   = m_pd1 ? 0 : ref_tab[m_addr1];
      m_sq    = (m_amp > 0);
      m_addr1 = m_acc[31:22] + {m_ph, 5'b0};
      m_pd1   = m_pd;
      m_acc   = m_pd ? 32'd0 : m_acc + m_fq;
      if (load_i) begin
         m_fq = freq_i; m_ph = ph_i; m_pd = pd_i;
      end
      @(negedge clk);
      check({tag, " amp"}, int'(amp), m_amp);
      check({"R8 square"}, int'(sq), int'(m_sq));
   endtask

   task automatic do_load(input logic [31:0] f, input logic [4:0] p, input logic d, input string tag);
      freq_i = f; ph_i = p; pd_i = d; load_i = 1'b1;
      tick(tag);
      load_i = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < 1024; k++) ref_tab[k] = ref_sine(k);
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 reset amp", int'(amp), 0);
      check("R1 reset square", int'(sq), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) tick("R1 idle");
      check("R1 after release", int'(amp), 0);

      // R3: sub-address word keeps the address at zero
      do_load(32'd1, 5'd0, 1'b0, "R3 load");
      for (int i = 0; i < 100; i++) tick("R3 truncation");
      check("R3 held at entry 0", int'(amp), 0);

      // R4/R9: one address step per clock covers the whole table
      do_load(32'd0, 5'd0, 1'b1, "R7 reset phase");
      tick("R7"); tick("R7");
      do_load(32'h0040_0000, 5'd0, 1'b0, "R9 load");
      // phase 0 present now; its sample appears two edges later
      tick("R9 latency");
      tick("R9 latency");
      check("R9 first sample", int'(amp), ref_tab[0]);
      tick("R9 latency");
      check("R9 second sample", int'(amp), ref_tab[1]);
      for (int i = 0; i < 1100; i++) tick("R4 table sweep");

      // R6: input changes without load are ignored
      freq_i = 32'h1234_5678; ph_i = 5'd17; pd_i = 1'b1;
      for (int i = 0; i < 20; i++) tick("R6 no load");
      check("R6 output still running", int'(amp != 0 || sq == 0), 1);

      // R5: every phase offset with a frozen zero phase
      for (int p = 0; p < 32; p++) begin
         do_load(32'd0, 5'd0, 1'b1, "R7 clear");
         tick("R7 clear");
         do_load(32'd0, 5'(p), 1'b0, "R5 load");
         tick("R5"); tick("R5"); tick("R5");
         check($sformatf("R5 offset %0d", p), int'(amp), ref_tab[(p * 32) % 1024]);
      end

      // R2: words above 2^31 wrap modulo 2^32
      do_load(32'hC123_4567, 5'd3, 1'b0, "R2 load");
      for (int i = 0; i < 300; i++) tick("R2 wrap");
      do_load(32'hFFFF_FFFF, 5'd0, 1'b0, "R2 load");
      for (int i = 0; i < 50; i++) tick("R2 wrap");
      do_load(32'h8000_0001, 5'd9, 1'b0, "R2 load");
      for (int i = 0; i < 50; i++) tick("R2 wrap");

      // assorted words
      for (int n = 0; n < 8; n++) begin
         do_load(32'h0123_4567 * (n + 3) + 32'h0050_0000 * n, 5'(n * 5), 1'b0, "R2 pattern");
         for (int i = 0; i < 64; i++) tick("R4 pattern");
      end

      // R7: power-down zeroes the outputs, release restarts at phase zero
      do_load(32'h0700_0000, 5'd0, 1'b1, "R7 enter");
      tick("R7"); tick("R7");
      check("R7 amp zero", int'(amp), 0);
      check("R7 square zero", int'(sq), 0);
      for (int i = 0; i < 10; i++) tick("R7 held");
      do_load(32'h0100_0000, 5'd0, 1'b0, "R7 release");
      tick("R7 restart"); tick("R7 restart");
      check("R7 restart sample", int'(amp), ref_tab[0]);
      tick("R7 restart");
      check("R7 next sample", int'(amp), ref_tab[4]);
      for (int i = 0; i < 40; i++) tick("R7 run");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule